// File: doc/BRIEF.md
# Receive Interrupt Coalescing Unit

This unit sits between a receive datapath and an interrupt controller. It collapses many per-frame completion events into fewer interrupts. Each completed frame arrives as a one-cycle `frame_done` pulse. An accompanying `frame_irq_req` flag says whether that frame asks for an interrupt at all.

While coalescing is on, two thresholds race each other, and whichever is reached first raises the interrupt:

- **Frame count:** a frame counter counts flagged frames up to a programmed value.
- **Hold-off timer:** the first flagged frame starts a timer. The timer counts down in units of 64 periods of a selectable time base. That base is either the core clock or an external slow tick enable.

Once the interrupt fires, both mechanisms re-arm. The counter starts again from zero, and the timer sits idle until the next flagged frame arrives. While coalescing is off, every flagged frame raises the interrupt directly.

The interrupt output is a level. It stays high until software acknowledges it.

Top module: `rxic_coalescer`

## Requirements
- R1: After a synchronous reset, `irq_out` is low.
- R2: With `coal_en` low, a flagged frame (`frame_done` and `frame_irq_req` both high in one cycle) drives `irq_out` high at the next clock edge.
- R3: A frame with `frame_irq_req` low neither advances the frame count nor starts the hold-off timer, and on its own never raises `irq_out`.
- R4: With `coal_en` high and count threshold N, `irq_out` rises at the edge that samples the N-th flagged frame since the last interrupt, and not earlier.
- R5: With `tick_sel` = 0 and timer threshold T, `irq_out` rises exactly 64*T clock cycles after the edge that sampled the first flagged frame, if the count has not been reached first.
- R6: Flagged frames that arrive while the timer is running do not restart or reload it.
- R7: When an interrupt fires, the frame count returns to zero and the timer stops. Without new flagged frames no further interrupt follows.
- R8: `irq_out` stays high until `irq_ack` is sampled high, and it drops at that edge.
- R9: With `tick_sel` = 1, the timer advances only on cycles where `ref_tick` is high. The interrupt rises at the edge carrying the 64*T-th `ref_tick` pulse after arming.
- R10: When a count hit and a timer expiry fall in the same cycle, exactly one interrupt results, and no second one follows.
- R11: A zero threshold is an illegal setting that behaves like one. A count threshold of 0 fires on every flagged frame. A timer threshold of 0 fires after 64 time-base periods.
- R12: If a new interrupt fires in the same cycle as `irq_ack`, `irq_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle pulse per completed received frame |
| frame_irq_req | input | 1 | Frame requests an interrupt (qualifies `frame_done`) |
| coal_en | input | 1 | Coalescing enable; 0 passes flagged frames straight through |
| cnt_thresh | input | 8 | Flagged frames needed for an interrupt |
| tmr_thresh | input | 16 | Hold-off limit in units of 64 time-base periods |
| tick_sel | input | 1 | Time base: 0 core clock, 1 `ref_tick` enable |
| ref_tick | input | 1 | Slow reference tick enable, one cycle wide |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_out | output | 1 | Level interrupt request |

## Verification
The assertions cover several rules on every cycle:
- the pass-through path while coalescing is off;
- how the level is held and cleared against acknowledge, including set-over-clear priority;
- that the timer halts after each interrupt;
- that the count and timer state stay still when no qualifying event occurs.

Other behaviour only the bench scenarios can show. This covers the exact interrupt latency:
- in cycles, or in reference ticks;
- when a second frame arrives mid-window;
- when a count hit and a timer expiry coincide;
- when a threshold is zero.

// File: rtl/rxic_pkg.sv
package rxic_pkg;

    parameter int CNT_W = 8;
    parameter int TMR_W = 16;
    parameter int PRE_W = 6;

    localparam int PRE_LAST = (1 << PRE_W) - 1;

    typedef struct packed {
        logic             enable;
        logic [CNT_W-1:0] cnt_limit;
        logic [TMR_W-1:0] tmr_limit;
        logic             slow_base;
    } rxic_cfg_t;

    typedef struct packed {
        logic cnt_hit;
        logic tmr_expire;
        logic direct;
    } rxic_cause_t;

    function automatic logic cause_any(input rxic_cause_t c);
        return c.cnt_hit | c.tmr_expire | c.direct;
    endfunction

endpackage

// File: rtl/rxic_prescaler.sv
module rxic_prescaler
    import rxic_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic slow_base,
    input  logic ref_tick,
    output logic adv
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    logic [W-1:0] pre_q;
    logic         src_en;

    assign src_en = slow_base ? ref_tick : 1'b1;
    assign adv    = run && src_en && (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (src_en) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_PRE_GATED: assert property (@(posedge clk) disable iff (rst)
        (run && !src_en) |=> $stable(pre_q)) else $error("prescaler moved without time base"); // R9

endmodule

// File: rtl/rxic_frame_counter.sv
module rxic_frame_counter
    import rxic_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] seen_q;
    logic [W:0]   next_seen;

    assign next_seen = {1'b0, seen_q} + 1'b1;
    assign hit       = inc && (next_seen >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear || hit) begin
            seen_q <= '0;
        end else if (inc) begin
            seen_q <= next_seen[W-1:0];
        end
    end

    AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clear) |=> $stable(seen_q)) else $error("count moved without a flagged frame"); // R3

endmodule

// File: rtl/rxic_holdoff_timer.sv
module rxic_holdoff_timer
    import rxic_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         stop,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         running,
    output logic         expire
);
    logic [W-1:0] val_q;
    logic         run_q;

    assign running = run_q;
    assign expire  = run_q && adv && (val_q <= {{(W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            run_q <= 1'b0;
            if (rst) begin
                val_q <= '0;
            end
        end else if (arm && !run_q) begin
            run_q <= 1'b1;
            val_q <= limit;
        end else if (adv && val_q != '0) begin
            val_q <= val_q - 1'b1;
        end
    end

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_q && !adv && !stop) |=> $stable(val_q)) else $error("timer changed off tick"); // R6

    AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (run_q && arm && !adv && !stop) |=> (run_q && val_q == $past(val_q))) else $error("timer rearmed"); // R6

endmodule

// File: rtl/rxic_coalescer.sv
module rxic_coalescer
    import rxic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done,
    input  logic             frame_irq_req,
    input  logic             coal_en,
    input  logic [CNT_W-1:0] cnt_thresh,
    input  logic [TMR_W-1:0] tmr_thresh,
    input  logic             tick_sel,
    input  logic             ref_tick,
    input  logic             irq_ack,
    output logic             irq_out
);
    rxic_cfg_t   cfg;
    rxic_cause_t cause;
    logic        flagged;
    logic        fire;
    logic        tmr_running;
    logic        tmr_adv;
    logic        irq_q;

    assign cfg = '{enable: coal_en, cnt_limit: cnt_thresh,
                   tmr_limit: tmr_thresh, slow_base: tick_sel};

    assign flagged      = frame_done && frame_irq_req;
    assign cause.direct = !cfg.enable && flagged;
    assign fire         = cause_any(cause);

    rxic_frame_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .inc   (cfg.enable && flagged),
        .clear (fire || !cfg.enable),
        .limit (cfg.cnt_limit),
        .hit   (cause.cnt_hit)
    );

    rxic_prescaler #(.W(PRE_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (tmr_running),
        .slow_base (cfg.slow_base),
        .ref_tick  (ref_tick),
        .adv       (tmr_adv)
    );

    rxic_holdoff_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .arm     (cfg.enable && flagged),
        .stop    (fire || !cfg.enable),
        .adv     (tmr_adv),
        .limit   (cfg.tmr_limit),
        .running (tmr_running),
        .expire  (cause.tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (fire) begin
            irq_q <= 1'b1;
        end else if (irq_ack) begin
            irq_q <= 1'b0;
        end
    end

    assign irq_out = irq_q;

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !irq_out) else $error("irq after reset"); // R1

    AST_DIRECT_IRQ: assert property (@(posedge clk) disable iff (rst)
        (!coal_en && frame_done && frame_irq_req) |=> irq_out) else $error("pass-through missed"); // R2

    AST_UNFLAGGED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!(frame_done && frame_irq_req) && !tmr_running && !irq_out) |=> !irq_out) else $error("spurious irq"); // R3

    AST_TMR_STOPS: assert property (@(posedge clk) disable iff (rst)
        fire |=> !tmr_running) else $error("timer still running after irq"); // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_out && !irq_ack) |=> irq_out) else $error("irq dropped without ack"); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_out && irq_ack && !fire) |=> !irq_out) else $error("ack ignored"); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        fire |=> irq_out) else $error("new irq lost"); // R12

endmodule

// File: tb/tb_rxic_coalescer.sv
module tb_rxic_coalescer;
    logic        clk = 1'b0;
    logic        rst;
    logic        frame_done, frame_irq_req, coal_en, tick_sel, ref_tick, irq_ack;
    logic [7:0]  cnt_thresh;
    logic [15:0] tmr_thresh;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    rxic_coalescer dut (
        .clk(clk), .rst(rst), .frame_done(frame_done), .frame_irq_req(frame_irq_req),
        .coal_en(coal_en), .cnt_thresh(cnt_thresh), .tmr_thresh(tmr_thresh),
        .tick_sel(tick_sel), .ref_tick(ref_tick), .irq_ack(irq_ack), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=hung exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // {coal_en, count threshold}: count path with a long timer
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'd1}, {1'b1, 8'd2}, {1'b1, 8'd3},
        {1'b1, 8'd5}, {1'b1, 8'd8}, {1'b0, 8'd4}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; frame_done = 0; frame_irq_req = 0; irq_ack = 0; ref_tick = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input logic req);
        @(negedge clk);
        frame_done = 1'b1; frame_irq_req = req;
        @(negedge clk);
        frame_done = 1'b0; frame_irq_req = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // waits up to maxc cycles; returns cycles elapsed and ref pulses delivered
    task automatic wait_irq(input int maxc, input logic use_ref, output int cyc, output int refs);
        cyc = 0; refs = 0;
        for (int k = 1; k <= maxc; k++) begin
            ref_tick = use_ref && (k % 3 == 0);
            if (ref_tick) refs = refs + 1;
            @(negedge clk);
            cyc = k;
            if (irq_out) break;
        end
        ref_tick = 1'b0;
    endtask

    initial begin
        int c, r, nf;
        logic en;
        logic [7:0] n;
        rst = 1; frame_done = 0; frame_irq_req = 0; coal_en = 0; tick_sel = 0;
        ref_tick = 0; irq_ack = 0; cnt_thresh = 8'd1; tmr_thresh = 16'd1;
        do_reset();
        check("R1 reset", irq_out, 1'b0);

        // vector table: count threshold and pass-through
        for (int v = 0; v < 6; v++) begin
            {en, n} = VEC[v];
            coal_en = en; cnt_thresh = n; tmr_thresh = 16'd200; tick_sel = 0;
            do_reset();
            nf = en ? int'(n) : 1;
            for (int i = 0; i < nf; i++) begin
                pulse(1'b1);
                check(en ? "R4 count" : "R2 direct", irq_out, (i == nf - 1));
            end
            ack();
            check("R8 ack clears", irq_out, 1'b0);
        end

        // R3: unflagged frames ignored
        coal_en = 1; cnt_thresh = 8'd2; tmr_thresh = 16'd1; do_reset();
        for (int i = 0; i < 5; i++) pulse(1'b0);
        wait_irq(200, 1'b0, c, r);
        check("R3 unflagged quiet", irq_out, 1'b0);
        pulse(1'b1);
        check("R3 count untouched", irq_out, 1'b0);
        wait_irq(300, 1'b0, c, r);
        check_int("R3 timer armed by flagged only", c, 64);
        ack();

        // R5: timer latency
        cnt_thresh = 8'd200; tmr_thresh = 16'd3; do_reset();
        pulse(1'b1);
        wait_irq(1000, 1'b0, c, r);
        check_int("R5 timer latency", c, 192);
        // R8: held without ack
        repeat (10) @(negedge clk);
        check("R8 level held", irq_out, 1'b1);
        ack();
        check("R8 ack clears", irq_out, 1'b0);

        // R6: second frame does not reload
        tmr_thresh = 16'd2; do_reset();
        pulse(1'b1);
        wait_irq(50, 1'b0, c, r);
        check("R6 no early irq", irq_out, 1'b0);
        pulse(1'b1);
        wait_irq(500, 1'b0, c, r);
        check_int("R6 no reload", 52 + c, 128);
        ack();

        // R7: after count fire, timer stopped
        cnt_thresh = 8'd2; tmr_thresh = 16'd2; do_reset();
        pulse(1'b1);
        pulse(1'b1);
        check("R7 count fire", irq_out, 1'b1);
        ack();
        wait_irq(300, 1'b0, c, r);
        check("R7 timer idle", irq_out, 1'b0);

        // R9: reference tick time base
        tick_sel = 1; cnt_thresh = 8'd200; tmr_thresh = 16'd2; do_reset();
        pulse(1'b1);
        wait_irq(1000, 1'b1, c, r);
        check("R9 fired", irq_out, 1'b1);
        check_int("R9 ref ticks", r, 128);
        ack();
        tick_sel = 0;

        // R10: count hit and expiry in one cycle
        cnt_thresh = 8'd2; tmr_thresh = 16'd1; do_reset();
        pulse(1'b1);
        repeat (62) @(negedge clk);
        check("R10 none before", irq_out, 1'b0);
        pulse(1'b1);
        check("R10 single irq", irq_out, 1'b1);
        ack();
        wait_irq(300, 1'b0, c, r);
        check("R10 no second irq", irq_out, 1'b0);

        // R11: zero thresholds
        cnt_thresh = 8'd0; tmr_thresh = 16'd50; do_reset();
        pulse(1'b1);
        check("R11 zero count", irq_out, 1'b1);
        ack();
        cnt_thresh = 8'd200; tmr_thresh = 16'd0; do_reset();
        pulse(1'b1);
        wait_irq(500, 1'b0, c, r);
        check_int("R11 zero timer", c, 64);
        ack();

        // R12: new fire in same cycle as ack
        coal_en = 0; do_reset();
        pulse(1'b1);
        @(negedge clk);
        irq_ack = 1; frame_done = 1; frame_irq_req = 1;
        @(negedge clk);
        irq_ack = 0; frame_done = 0; frame_irq_req = 0;
        check("R12 set wins", irq_out, 1'b1);
        ack();
        check("R12 then clears", irq_out, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule